// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

This block is a processor core that completes one instruction in every clock cycle. At each rising edge it commits the instruction presented on its instruction port: it decodes the fixed 32-bit word, reads two operands from a 32-entry register file, and computes a result or a memory address. It then writes back into the register file and moves the program counter to the next, branch or jump address. Memory sits outside the block. The core drives a word address to an instruction memory and to a data memory, and both memories return read data combinationally within the same cycle. A store raises a one-cycle write strobe together with the address and the data.

The supported subset covers five register-register operations, four immediate operations, and the upper-immediate load. It also covers word load and store, the two equality branches, the direct jump, the jump that saves the return address, and the register-indirect jump. Any other encoding retires as a no-op. Register 0 is a constant zero.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC so that `imem_addr` reads 0x00000000 in the cycle after the reset edge. While `rst` is high, no register is written and `dmem_we` stays 0.
- R2: Opcode 0x00 selects a register-register operation with fields op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0], and the result goes to rd. The funct values are: 0x20 for rs+rt, 0x22 for rs-rt, 0x24 for bitwise AND, 0x25 for bitwise OR, and 0x2A for set-less-than. Set-less-than writes 1 when rs < rt as signed two's-complement values and 0 otherwise.
- R3: The immediate operations take their 16-bit immediate from [15:0] and write the result to rt. Opcode 0x08 adds, and opcode 0x0A is signed set-less-than; both sign-extend the immediate. Opcode 0x0C is AND and opcode 0x0D is OR; both zero-extend it.
- R4: Opcode 0x0F writes the immediate into bits [31:16] of rt and clears bits [15:0].
- R5: Register 0 always reads as zero, and any write aimed at it is discarded.
- R6: The word store (opcode 0x2B) and the word load (opcode 0x23) both use the address rs plus the sign-extended immediate, on `dmem_addr`. A store asserts `dmem_we` for that cycle and drives rt on `dmem_wdata`. A load writes `dmem_rdata` to rt.
- R7: Opcode 0x04 branches when rs equals rt, and opcode 0x05 branches when they differ. A taken branch sets the next PC to PC+4 plus the sign-extended immediate times 4. A branch that is not taken goes to PC+4.
- R8: Opcode 0x02 jumps and opcode 0x03 jumps and links. Both set the next PC to bits [31:28] of PC+4, followed by the 26-bit target [25:0], followed by two zero bits. Opcode 0x03 also writes PC+4 into register 31.
- R9: Opcode 0x00 with funct 0x08 loads the next PC from rs, with rs bits [1:0] forced to zero.
- R10: Certain encodings retire as a no-op that only advances the PC by 4: any other opcode, any other funct under opcode 0x00, and any opcode-0x00 word with a nonzero shamt. Such a no-op writes no register and no memory.
- R11: `imem_addr` bits [1:0] are always zero. Every non-control instruction advances `imem_addr` by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, returned in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, returned in the same cycle |

## Verification
Register contents are visible at the ports only when a store puts them on the write-data bus. Each operation under test is therefore wrapped as follows: two operands are built with the upper-immediate/OR pair, the operation runs, and a store of the destination register follows. Operand sweeps cross sign-boundary values for every arithmetic and logical form. The jump concatenation is hard to observe from a PC near zero, because the upper four PC bits stay zero there. The stimulus first uses a register-indirect jump to land the PC in the top address region, then issues a direct jump whose result must keep those upper bits.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int RAW   = $clog2(NREG);
    localparam int IMMW  = 16;
    localparam int TGTW  = 26;
    localparam int OPW   = 6;
    localparam int PCW   = XLEN - 2;
    localparam int LINKR = NREG - 1;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_JMP   = 6'h02;
    localparam logic [OPW-1:0] OP_JAL   = 6'h03;
    localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPW-1:0] OP_BNE   = 6'h05;
    localparam logic [OPW-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPW-1:0] OP_SLTI  = 6'h0A;
    localparam logic [OPW-1:0] OP_ANDI  = 6'h0C;
    localparam logic [OPW-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPW-1:0] OP_LUI   = 6'h0F;
    localparam logic [OPW-1:0] OP_LW    = 6'h23;
    localparam logic [OPW-1:0] OP_SW    = 6'h2B;

    localparam logic [OPW-1:0] FN_JR    = 6'h08;
    localparam logic [OPW-1:0] FN_ADD   = 6'h20;
    localparam logic [OPW-1:0] FN_SUB   = 6'h22;
    localparam logic [OPW-1:0] FN_AND   = 6'h24;
    localparam logic [OPW-1:0] FN_OR    = 6'h25;
    localparam logic [OPW-1:0] FN_SLT   = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_RT, DST_RD, DST_LINK
    } dst_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_LINK
    } wb_e;

    typedef enum logic [2:0] {
        PC_SEQ, PC_BEQ, PC_BNE, PC_JUMP, PC_REG
    } pc_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    src_imm;
        logic    imm_zext;
        logic    reg_wr;
        dst_e    dst;
        wb_e     wb;
        logic    mem_wr;
        pc_e     pc_sel;
    } ctrl_t;

endpackage

// File: rtl/sc_core_decode.sv
module sc_core_decode
    import sc_core_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [OPW-1:0] op;
    logic [OPW-1:0] funct;
    logic [4:0]     shamt;

    assign op    = instr[31:26];
    assign funct = instr[5:0];
    assign shamt = instr[10:6];

    always_comb begin
        ctrl = '{alu_op:   ALU_ADD,
                 src_imm:  1'b0,
                 imm_zext: 1'b0,
                 reg_wr:   1'b0,
                 dst:      DST_RT,
                 wb:       WB_ALU,
                 mem_wr:   1'b0,
                 pc_sel:   PC_SEQ};
        unique case (op)
            OP_RTYPE: begin
                if (shamt == 5'd0) begin
                    unique case (funct)
                        FN_ADD: begin ctrl.alu_op = ALU_ADD; ctrl.reg_wr = 1'b1; ctrl.dst = DST_RD; end
                        FN_SUB: begin ctrl.alu_op = ALU_SUB; ctrl.reg_wr = 1'b1; ctrl.dst = DST_RD; end
                        FN_AND: begin ctrl.alu_op = ALU_AND; ctrl.reg_wr = 1'b1; ctrl.dst = DST_RD; end
                        FN_OR:  begin ctrl.alu_op = ALU_OR;  ctrl.reg_wr = 1'b1; ctrl.dst = DST_RD; end
                        FN_SLT: begin ctrl.alu_op = ALU_SLT; ctrl.reg_wr = 1'b1; ctrl.dst = DST_RD; end
                        FN_JR:  ctrl.pc_sel = PC_REG;
                        default: ;
                    endcase
                end
            end
            OP_ADDI: begin ctrl.alu_op = ALU_ADD; ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; end
            OP_SLTI: begin ctrl.alu_op = ALU_SLT; ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; end
            OP_ANDI: begin
                ctrl.alu_op = ALU_AND; ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_wr = 1'b1;
            end
            OP_ORI: begin
                ctrl.alu_op = ALU_OR; ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_wr = 1'b1;
            end
            OP_LUI: begin
                ctrl.alu_op = ALU_LUI; ctrl.src_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.reg_wr = 1'b1;
            end
            OP_LW: begin
                ctrl.alu_op = ALU_ADD; ctrl.src_imm = 1'b1; ctrl.reg_wr = 1'b1; ctrl.wb = WB_MEM;
            end
            OP_SW: begin
                ctrl.alu_op = ALU_ADD; ctrl.src_imm = 1'b1; ctrl.mem_wr = 1'b1;
            end
            OP_BEQ: ctrl.pc_sel = PC_BEQ;
            OP_BNE: ctrl.pc_sel = PC_BNE;
            OP_JMP: ctrl.pc_sel = PC_JUMP;
            OP_JAL: begin
                ctrl.pc_sel = PC_JUMP; ctrl.reg_wr = 1'b1; ctrl.dst = DST_LINK; ctrl.wb = WB_LINK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile
    import sc_core_pkg::*;
(
    input  logic            clk,
    input  logic            wr_en,
    input  logic [RAW-1:0]  wr_idx,
    input  logic [XLEN-1:0] wr_val,
    input  logic [RAW-1:0]  rd_idx_a,
    input  logic [RAW-1:0]  rd_idx_b,
    output logic [XLEN-1:0] rd_val_a,
    output logic [XLEN-1:0] rd_val_b
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx != '0)) begin
            regs[wr_idx] <= wr_val;
        end
    end

    assign rd_val_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
    assign rd_val_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
    import sc_core_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_LUI: y = {b[IMMW-1:0], {(XLEN-IMMW){1'b0}}};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    ctrl_t           ctrl;
    logic [PCW-1:0]  pc_w;
    logic [PCW-1:0]  pc_seq_w;
    logic [PCW-1:0]  pc_nxt_w;
    logic [PCW-1:0]  br_off_w;
    logic [RAW-1:0]  rs_idx;
    logic [RAW-1:0]  rt_idx;
    logic [RAW-1:0]  rd_idx;
    logic [RAW-1:0]  wr_idx;
    logic [IMMW-1:0] imm;
    logic [TGTW-1:0] tgt;
    logic [XLEN-1:0] rs_data;
    logic [XLEN-1:0] rt_data;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] link_val;
    logic [XLEN-1:0] wb_val;
    logic            reg_we;
    logic            ops_equal;

    assign rs_idx = imem_data[25:21];
    assign rt_idx = imem_data[20:16];
    assign rd_idx = imem_data[15:11];
    assign imm    = imem_data[IMMW-1:0];
    assign tgt    = imem_data[TGTW-1:0];

    sc_core_decode decode_i (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    sc_core_regfile regfile_i (
        .clk      (clk),
        .wr_en    (reg_we),
        .wr_idx   (wr_idx),
        .wr_val   (wb_val),
        .rd_idx_a (rs_idx),
        .rd_idx_b (rt_idx),
        .rd_val_a (rs_data),
        .rd_val_b (rt_data)
    );

    assign imm_ext = ctrl.imm_zext ? {{(XLEN-IMMW){1'b0}}, imm}
                                   : {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

    sc_core_alu alu_i (
        .op (ctrl.alu_op),
        .a  (rs_data),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Write-back selection
    assign link_val = {pc_seq_w, 2'b00};

    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   wr_idx = rd_idx;
            DST_LINK: wr_idx = RAW'(LINKR);
            default:  wr_idx = rt_idx;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  wb_val = dmem_rdata;
            WB_LINK: wb_val = link_val;
            default: wb_val = alu_y;
        endcase
    end

    assign reg_we     = ctrl.reg_wr & ~rst;
    assign dmem_we    = ctrl.mem_wr & ~rst;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_data;

    // Next-PC selection, kept as a word address
    assign ops_equal = (rs_data == rt_data);
    assign pc_seq_w  = pc_w + 1'b1;
    assign br_off_w  = {{(PCW-IMMW){imm[IMMW-1]}}, imm};

    always_comb begin
        unique case (ctrl.pc_sel)
            PC_BEQ:  pc_nxt_w = ops_equal ? pc_seq_w + br_off_w : pc_seq_w;
            PC_BNE:  pc_nxt_w = ops_equal ? pc_seq_w : pc_seq_w + br_off_w;
            PC_JUMP: pc_nxt_w = {pc_seq_w[PCW-1:TGTW], tgt};
            PC_REG:  pc_nxt_w = rs_data[XLEN-1:2];
            default: pc_nxt_w = pc_seq_w;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_w <= '0;
        end else begin
            pc_w <= pc_nxt_w;
        end
    end

    assign imem_addr = {pc_w, 2'b00};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_core_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr,
    input logic [XLEN-1:0] imem_data,
    input logic            dmem_we,
    input logic [XLEN-1:0] dmem_addr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val
);

    logic [OPW-1:0]  op;
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] sext;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;
    logic            is_flow;
    logic            rst_seen = 1'b0;

    assign op      = imem_data[31:26];
    assign pc4     = imem_addr + 32'd4;
    assign sext    = {{16{imem_data[15]}}, imem_data[15:0]};
    assign br_tgt  = pc4 + {sext[29:0], 2'b00};
    assign jmp_tgt = {pc4[31:28], imem_data[25:0], 2'b00};
    assign is_flow = (op == OP_RTYPE) || (op == OP_JMP) || (op == OP_JAL) ||
                     (op == OP_BEQ) || (op == OP_BNE);

    always_ff @(posedge clk) begin
        if (rst_seen) begin
            assert_pc_reset_R1: assert (imem_addr == 32'h0);
        end
        rst_seen <= rst;
    end

    assert_no_store_in_reset_R1: assert property (@(posedge clk) rst |-> !dmem_we);

    assert_store_addr_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (op == OP_SW) && (dmem_addr == rs_val + sext));

    assert_beq_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ && rs_val == rt_val) |=> imem_addr == $past(br_tgt));

    assert_bne_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BNE && rs_val == rt_val) |=> imem_addr == $past(pc4));

    assert_jump_concat_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JMP || op == OP_JAL) |=> imem_addr == $past(jmp_tgt));

    assert_pc_aligned_R11: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);

    assert_seq_step_R11: assert property (@(posedge clk) disable iff (rst)
        !is_flow |=> imem_addr == $past(pc4));

endmodule

bind sc_core sc_core_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .dmem_addr (dmem_addr),
    .rs_val    (rs_data),
    .rt_val    (rt_data)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    localparam int CLK_NS = 4;

    localparam logic [5:0] T_J = 6'h02, T_JAL = 6'h03, T_BEQ = 6'h04, T_BNE = 6'h05;
    localparam logic [5:0] T_ADDI = 6'h08, T_SLTI = 6'h0A, T_ANDI = 6'h0C, T_ORI = 6'h0D;
    localparam logic [5:0] T_LUI = 6'h0F, T_LW = 6'h23, T_SW = 6'h2B;
    localparam logic [5:0] F_JR = 6'h08, F_ADD = 6'h20, F_SUB = 6'h22;
    localparam logic [5:0] F_AND = 6'h24, F_OR = 6'h25, F_SLT = 6'h2A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data = 32'h0;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;
    logic [31:0] dmem [1024];

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] last_pc;
    logic        cap_we;
    logic [31:0] cap_addr;
    logic [31:0] cap_wdata;

    always #(CLK_NS/2) clk = ~clk;

    sc_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign dmem_rdata = dmem[dmem_addr[11:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[11:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] im);
        return {op, rs, rt, im};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] im);
        return {{16{im[15]}}, im};
    endfunction

    function automatic logic [31:0] r_expect(input logic [5:0] fn, input logic [31:0] a, b);
        case (fn)
            F_ADD:   return a + b;
            F_SUB:   return a - b;
            F_AND:   return a & b;
            F_OR:    return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic exec(input logic [31:0] ins);
        @(negedge clk);
        imem_data = ins;
        #1;
        last_pc   = imem_addr;
        cap_we    = dmem_we;
        cap_addr  = dmem_addr;
        cap_wdata = dmem_wdata;
        @(posedge clk);
    endtask

    task automatic setreg(input logic [4:0] r, input logic [31:0] v);
        exec(enc_i(T_LUI, 5'd0, r, v[31:16]));
        exec(enc_i(T_ORI, r, r, v[15:0]));
    endtask

    task automatic readreg(input logic [4:0] r, output logic [31:0] v);
        exec(enc_i(T_SW, 5'd0, r, 16'h07F0));
        v = cap_wdata;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_err++;
        $display("FAIL R1 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] vals [8];
        logic [15:0] imms [6];
        logic [5:0]  fns  [5];
        logic [31:0] v, p, e;

        vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h5, 32'hFFFF_FFFB, 32'h1234_5678};
        imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        fns  = '{F_ADD, F_SUB, F_AND, F_OR, F_SLT};
        for (int i = 0; i < 1024; i++) dmem[i] = 32'h0;

        // R1: reset holds PC at zero and blocks stores
        repeat (2) @(posedge clk);
        @(negedge clk);
        imem_data = enc_i(T_SW, 5'd0, 5'd0, 16'h0010);
        #1;
        chk("R1 no store during reset", {31'b0, dmem_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        imem_data = 32'h0;
        #1;
        chk("R1 pc after reset", imem_addr, 32'h0);

        // R11: sequential stepping
        exec(32'h0);
        p = last_pc;
        exec(enc_i(T_ADDI, 5'd0, 5'd1, 16'h0003));
        chk("R11 pc step 1", last_pc, p + 32'd4);
        exec(enc_i(T_ORI, 5'd0, 5'd2, 16'h0003));
        chk("R11 pc step 2", last_pc, p + 32'd8);
        exec(32'h0);
        chk("R11 pc step 3", last_pc, p + 32'd12);

        // R2: register-register sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                setreg(5'd1, vals[i]);
                setreg(5'd2, vals[j]);
                for (int k = 0; k < 5; k++) begin
                    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, fns[k]));
                    readreg(5'd3, v);
                    chk($sformatf("R2 funct %h a %h b %h", fns[k], vals[i], vals[j]),
                        v, r_expect(fns[k], vals[i], vals[j]));
                end
            end
        end

        // R3: immediate sweep
        for (int i = 0; i < 8; i++) begin
            setreg(5'd1, vals[i]);
            for (int j = 0; j < 6; j++) begin
                exec(enc_i(T_ADDI, 5'd1, 5'd4, imms[j]));
                readreg(5'd4, v);
                chk("R3 addi", v, vals[i] + sx(imms[j]));
                exec(enc_i(T_SLTI, 5'd1, 5'd4, imms[j]));
                readreg(5'd4, v);
                chk("R3 slti", v, ($signed(vals[i]) < $signed(sx(imms[j]))) ? 32'd1 : 32'd0);
                exec(enc_i(T_ANDI, 5'd1, 5'd4, imms[j]));
                readreg(5'd4, v);
                chk("R3 andi", v, vals[i] & {16'h0, imms[j]});
                exec(enc_i(T_ORI, 5'd1, 5'd4, imms[j]));
                readreg(5'd4, v);
                chk("R3 ori", v, vals[i] | {16'h0, imms[j]});
            end
        end

        // R4: upper immediate clears the low half
        for (int j = 0; j < 6; j++) begin
            setreg(5'd5, 32'hFFFF_FFFF);
            exec(enc_i(T_LUI, 5'd0, 5'd5, imms[j]));
            readreg(5'd5, v);
            chk("R4 lui", v, {imms[j], 16'h0});
        end

        // R5: register zero
        exec(enc_i(T_ADDI, 5'd0, 5'd0, 16'h0005));
        readreg(5'd0, v);
        chk("R5 addi to r0", v, 32'h0);
        setreg(5'd1, 32'h1111_2222);
        exec(enc_r(5'd1, 5'd1, 5'd0, 5'd0, F_ADD));
        exec(enc_i(T_LUI, 5'd0, 5'd0, 16'hABCD));
        readreg(5'd0, v);
        chk("R5 add/lui to r0", v, 32'h0);
        exec(enc_r(5'd0, 5'd1, 5'd3, 5'd0, F_OR));
        readreg(5'd3, v);
        chk("R5 r0 reads zero", v, 32'h1111_2222);

        // R6: store and load with negative and positive offsets
        setreg(5'd6, 32'h0000_0200);
        setreg(5'd7, 32'hDEAD_BEEF);
        exec(enc_i(T_SW, 5'd6, 5'd7, 16'hFFF8));
        chk("R6 sw strobe", {31'b0, cap_we}, 32'd1);
        chk("R6 sw addr", cap_addr, 32'h0000_01F8);
        chk("R6 sw data", cap_wdata, 32'hDEAD_BEEF);
        setreg(5'd7, 32'h0BAD_F00D);
        exec(enc_i(T_SW, 5'd6, 5'd7, 16'h0010));
        chk("R6 sw addr pos", cap_addr, 32'h0000_0210);
        exec(enc_i(T_LW, 5'd6, 5'd8, 16'hFFF8));
        chk("R6 lw no strobe", {31'b0, cap_we}, 32'd0);
        readreg(5'd8, v);
        chk("R6 lw neg offset", v, 32'hDEAD_BEEF);
        exec(enc_i(T_LW, 5'd6, 5'd8, 16'h0010));
        readreg(5'd8, v);
        chk("R6 lw pos offset", v, 32'h0BAD_F00D);
        exec(enc_i(T_LW, 5'd6, 5'd0, 16'h0010));
        readreg(5'd0, v);
        chk("R5 lw to r0", v, 32'h0);

        // R7: branches
        setreg(5'd1, 32'h0000_00AA);
        setreg(5'd2, 32'h0000_00AA);
        setreg(5'd3, 32'h0000_00AB);
        exec(enc_i(T_BEQ, 5'd1, 5'd2, 16'h0005));
        p = last_pc;
        exec(32'h0);
        chk("R7 beq taken", last_pc, p + 32'd4 + 32'd20);
        exec(enc_i(T_BEQ, 5'd1, 5'd3, 16'h0005));
        p = last_pc;
        exec(32'h0);
        chk("R7 beq not taken", last_pc, p + 32'd4);
        exec(enc_i(T_BNE, 5'd1, 5'd3, 16'hFFFE));
        p = last_pc;
        exec(32'h0);
        chk("R7 bne taken back", last_pc, p + 32'd4 - 32'd8);
        exec(enc_i(T_BNE, 5'd1, 5'd2, 16'h0040));
        p = last_pc;
        exec(32'h0);
        chk("R7 bne not taken", last_pc, p + 32'd4);

        // R8: jump and jump-and-link
        exec(enc_j(T_J, 26'h010_0008));
        p = last_pc + 32'd4;
        exec(32'h0);
        chk("R8 j target", last_pc, {p[31:28], 26'h010_0008, 2'b00});
        exec(enc_j(T_JAL, 26'h000_0040));
        p = last_pc;
        exec(32'h0);
        chk("R8 jal target", last_pc, {p[31:28] + 4'h0, 26'h000_0040, 2'b00});
        readreg(5'd31, v);
        chk("R8 jal link", v, p + 32'd4);

        // R9: register jump, unaligned source
        setreg(5'd9, 32'h0000_1237);
        exec(enc_r(5'd9, 5'd0, 5'd0, 5'd0, F_JR));
        exec(32'h0);
        chk("R9 jr drops low bits", last_pc, 32'h0000_1234);
        chk("R11 pc aligned", {30'b0, last_pc[1:0]}, 32'h0);

        // R8: concatenation keeps upper PC bits
        setreg(5'd9, 32'hF000_0010);
        exec(enc_r(5'd9, 5'd0, 5'd0, 5'd0, F_JR));
        exec(32'h0);
        chk("R9 jr high", last_pc, 32'hF000_0010);
        exec(enc_j(T_J, 26'h000_0100));
        exec(32'h0);
        chk("R8 j keeps upper bits", last_pc, 32'hF000_0400);

        // R10: out-of-subset encodings
        setreg(5'd10, 32'hCAFE_0001);
        setreg(5'd1, 32'h0000_0003);
        setreg(5'd2, 32'h0000_0004);
        exec(enc_i(6'h3F, 5'd1, 5'd10, 16'h1234));
        p = last_pc;
        chk("R10 bad op no store", {31'b0, cap_we}, 32'd0);
        exec(enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h03));
        chk("R10 bad op pc+4", last_pc, p + 32'd4);
        exec(enc_r(5'd1, 5'd2, 5'd10, 5'd3, F_ADD));
        chk("R10 bad funct pc+4", last_pc, p + 32'd8);
        exec(enc_i(6'h20, 5'd1, 5'd10, 16'h0000));
        chk("R10 shamt add pc+4", last_pc, p + 32'd12);
        e = 32'hCAFE_0001;
        readreg(5'd10, v);
        chk("R10 no register write", v, e);

        // R1: reset mid-run blocks writes and returns PC to zero
        setreg(5'd11, 32'h0000_55AA);
        @(negedge clk);
        rst = 1'b1;
        imem_data = enc_i(T_ADDI, 5'd0, 5'd11, 16'h0007);
        #1;
        chk("R1 no store strobe in reset", {31'b0, dmem_we}, 32'd0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        imem_data = 32'h0;
        #1;
        chk("R1 pc zero after reset", imem_addr, 32'h0);
        readreg(5'd11, v);
        chk("R1 no write during reset", v, 32'h0000_55AA);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule